// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that a processor drives through a small register bus. Software sets the mode, the chip-select line and the bit-rate divider, loads bytes into a 16-entry transmit FIFO, and sets the run bit. The controller shifts one 8-bit word, most significant bit first, for every transmit entry, in any of the four clock-polarity/phase combinations. Each received word goes into a 16-entry receive FIFO that software drains through the same data port.

Software can work from an interrupt. It is told when the receive FIFO holds enough bytes to be worth reading, or when the transmit FIFO has run dry with no word in flight. Setting the run bit with nothing queued raises the finished condition at once, so a driver can start a transfer and fill the FIFO from its first interrupt. Clearing the run bit stops the transfer and releases the chip select.

Top module: `spi_host_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control/status), 0x4 (FIFO data) and 0x8 (divider). After reset the control/status word reads 0x0004_0000, the divider reads 0, `irq` is low and every chip-select output sits at its inactive level (high).
- R2: A write to 0x4 pushes `wdata[7:0]` into the transmit FIFO and is dropped when that FIFO already holds 16 bytes. A read of 0x4 returns the oldest received byte in bits 7:0 and removes it. A read of 0x4 returns 0 when the receive FIFO is empty.
- R3: For each transmit entry the controller moves 8 bits MSB first. `sclk` rests at the control bit 3 (clock polarity) level. When control bit 2 (clock phase) is 0, data is sampled on the leading clock edge and changed on the trailing edge. When it is 1, data changes on the leading edge and is sampled on the trailing edge.
- R4: Each `sclk` half period lasts divider[15:1] system clocks. Bit 0 of the divider is ignored. A value whose bits 15:1 are all zero gives a half period of 32768 clocks.
- R5: Control bits 1:0 pick chip-select line 0, 1 or 2. The value 3 picks none. While the run bit (control bit 7) is set, the picked line is driven to its active level, which is high when control bit 6 or that line's own polarity bit is set. The polarity bits are control bits 21, 22 and 23 for lines 0, 1 and 2. Every other line, and every line while run is clear, sits at the opposite level.
- R6: Status bit 16 (finished) is high exactly when run is set, the transmit FIFO is empty and no word is in flight.
- R7: Status bit 17 shows the receive FIFO is non-empty, bit 18 shows the transmit FIFO has room, and bit 20 shows the receive FIFO holds 16 bytes.
- R8: Status bit 19 is high while the receive FIFO holds 12 or more bytes.
- R9: `irq` is high when (bit 16 and control bit 9) or (bit 19 and control bit 10).
- R10: Writing 1 to control bit 4 empties the transmit FIFO, and writing 1 to control bit 5 empties the receive FIFO. Both bits always read back 0.
- R11: No word starts while the receive FIFO is full. Shifting resumes after a byte is read from it.
- R12: Clearing run aborts a word in flight. No partial byte enters the receive FIFO, and from the second cycle after the write `sclk` rests at the polarity level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select lines, per-line polarity |
| irq | output | 1 | Interrupt request |

## Verification
The serial path is run in all four polarity/phase combinations against a behavioural slave that samples and launches data on the edges that mode defines. Each run uses a different divider, line and polarity setting, so a swapped edge or a bit-order error corrupts the exchanged bytes. Divider settings 6, 7 and 0 are timed on the wire, which separates a correct half period, the ignored low bit and the wrap to the slowest rate. Dedicated sequences fill the receive FIFO to 13 and to 16 bytes, overfill the transmit FIFO, clear each FIFO and abort mid-word. These tell threshold, stall, drop and flush behaviour apart, while every clock compares the chip-select lines with the level predicted from the last control write.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int CS_LINES = 3;
    localparam int SEL_W    = 2;
    localparam int WORD_W   = 8;
    localparam int DIV_W    = 16;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_DATA = 4'h4;
    localparam logic [3:0] OFS_DIV  = 4'h8;

    // stored control fields
    typedef struct packed {
        logic [CS_LINES-1:0] line_pol;
        logic                rxr_ie;
        logic                done_ie;
        logic                run;
        logic                glob_pol;
        logic                cpol;
        logic                cpha;
        logic [SEL_W-1:0]    sel;
    } ctrl_t;

    // live status flags
    typedef struct packed {
        logic rx_full;
        logic rx_need;
        logic tx_room;
        logic rx_avail;
        logic done;
    } flags_t;

    typedef enum logic [1:0] {REG_CTRL, REG_DATA, REG_DIV, REG_NONE} reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [3:0] a);
        case (a)
            OFS_CTRL: return REG_CTRL;
            OFS_DATA: return REG_DATA;
            OFS_DIV:  return REG_DIV;
            default:  return REG_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.sel      = w[1:0];
        c.cpha     = w[2];
        c.cpol     = w[3];
        c.glob_pol = w[6];
        c.run      = w[7];
        c.done_ie  = w[9];
        c.rxr_ie   = w[10];
        c.line_pol = w[23:21];
        return c;
    endfunction

    function automatic logic [31:0] status_word(input ctrl_t c, input flags_t f);
        logic [31:0] w;
        w        = '0;
        w[1:0]   = c.sel;
        w[2]     = c.cpha;
        w[3]     = c.cpol;
        w[6]     = c.glob_pol;
        w[7]     = c.run;
        w[9]     = c.done_ie;
        w[10]    = c.rxr_ie;
        w[20:16] = f;
        w[23:21] = c.line_pol;
        return w;
    endfunction

endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
    parameter int DIV_W  = 16,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  div,
    input  logic              tx_avail,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              rx_room,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_byte,
    output logic              busy,
    output logic              sclk,
    output logic              mosi
);
    localparam int EDGES = 2 * WORD_W;
    localparam int EW    = $clog2(EDGES);
    localparam logic [DIV_W-1:0] HALF_MAX = {1'b1, {(DIV_W-1){1'b0}}};

    logic [DIV_W-1:0]  half_len, hcnt;
    logic [EW-1:0]     edge_idx;
    logic              phase, mosi_q, tick, last_edge, sample_now;
    logic [WORD_W-1:0] tx_sh, rx_sh, rx_next;

    assign half_len   = (div[DIV_W-1:1] == '0) ? HALF_MAX : {1'b0, div[DIV_W-1:1]};
    assign tick       = busy && (hcnt == half_len - 1'b1);
    assign last_edge  = (edge_idx == EW'(EDGES - 1));
    // even edge index = leading edge; phase 0 samples there
    assign sample_now = (!edge_idx[0]) ^ cpha;
    assign rx_next    = {rx_sh[WORD_W-2:0], miso};

    assign tx_pop  = enable && !busy && tx_avail && rx_room;
    assign rx_push = enable && tick && last_edge;
    assign rx_byte = sample_now ? rx_next : rx_sh;
    assign sclk    = cpol ^ phase;
    assign mosi    = mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            phase    <= 1'b0;
            hcnt     <= '0;
            edge_idx <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            mosi_q   <= 1'b0;
        end else if (!enable) begin
            busy     <= 1'b0;
            phase    <= 1'b0;
            hcnt     <= '0;
            edge_idx <= '0;
        end else if (tx_pop) begin
            busy     <= 1'b1;
            hcnt     <= '0;
            edge_idx <= '0;
            if (!cpha) begin
                mosi_q <= tx_byte[WORD_W-1];
                tx_sh  <= {tx_byte[WORD_W-2:0], 1'b0};
            end else begin
                tx_sh  <= tx_byte;
            end
        end else if (tick) begin
            hcnt     <= '0;
            phase    <= ~phase;
            edge_idx <= edge_idx + 1'b1;
            if (sample_now) begin
                rx_sh <= rx_next;
            end else begin
                mosi_q <= tx_sh[WORD_W-1];
                tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
            end
            if (last_edge) busy <= 1'b0;
        end else if (busy) begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_host_csel.sv
module spi_host_csel
    import spi_host_pkg::*;
(
    input  logic                run,
    input  logic [SEL_W-1:0]    sel,
    input  logic                glob_pol,
    input  logic [CS_LINES-1:0] line_pol,
    output logic [CS_LINES-1:0] cs_o
);
    for (genvar i = 0; i < CS_LINES; i++) begin : g_line
        logic lvl, hit;
        assign lvl     = glob_pol | line_pol[i];
        assign hit     = run && (sel == SEL_W'(i));
        assign cs_o[i] = hit ? lvl : ~lvl;
    end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int FIFO_DEPTH    = 16,
    parameter int RX_NEED_LEVEL = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [CS_LINES-1:0] cs_o,
    output logic                irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    reg_sel_e          rsel;
    logic              wr_ctrl, wr_div, wr_data, rd_data, clr_tx, clr_rx;
    logic [WORD_W-1:0] tx_head, rx_head, eng_rx_byte;
    logic [CW-1:0]     tx_count, rx_count;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              eng_tx_pop, eng_rx_push, eng_busy;
    flags_t            flags;

    assign rsel    = decode_addr(bus_addr);
    assign wr_ctrl = bus_valid && bus_write && (rsel == REG_CTRL);
    assign wr_div  = bus_valid && bus_write && (rsel == REG_DIV);
    assign wr_data = bus_valid && bus_write && (rsel == REG_DATA);
    assign rd_data = bus_valid && !bus_write && (rsel == REG_DATA);
    assign clr_tx  = wr_ctrl && bus_wdata[4];
    assign clr_rx  = wr_ctrl && bus_wdata[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_from_word(bus_wdata);
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(clr_tx),
        .push(wr_data), .wdata(bus_wdata[WORD_W-1:0]),
        .pop(eng_tx_pop), .rdata(tx_head),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(clr_rx),
        .push(eng_rx_push), .wdata(eng_rx_byte),
        .pop(rd_data), .rdata(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    spi_host_shifter #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_eng (
        .clk(clk), .rst(rst), .enable(ctrl_q.run),
        .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .div(div_q),
        .tx_avail(!tx_empty), .tx_byte(tx_head), .rx_room(!rx_full),
        .miso(miso), .tx_pop(eng_tx_pop), .rx_push(eng_rx_push),
        .rx_byte(eng_rx_byte), .busy(eng_busy), .sclk(sclk), .mosi(mosi)
    );

    spi_host_csel u_cs (
        .run(ctrl_q.run), .sel(ctrl_q.sel), .glob_pol(ctrl_q.glob_pol),
        .line_pol(ctrl_q.line_pol), .cs_o(cs_o)
    );

    assign flags.done     = ctrl_q.run && tx_empty && !eng_busy;
    assign flags.rx_avail = !rx_empty;
    assign flags.tx_room  = !tx_full;
    assign flags.rx_need  = (rx_count >= CW'(RX_NEED_LEVEL));
    assign flags.rx_full  = rx_full;

    assign irq = (flags.done && ctrl_q.done_ie) || (flags.rx_need && ctrl_q.rxr_ie);

    always_comb begin
        case (rsel)
            REG_CTRL: bus_rdata = status_word(ctrl_q, flags);
            REG_DATA: bus_rdata = rx_empty ? 32'h0 : {{(32-WORD_W){1'b0}}, rx_head};
            REG_DIV:  bus_rdata = {{(32-DIV_W){1'b0}}, div_q};
            default:  bus_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk
    import spi_host_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NEED  = 12
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       run,
    input logic                       cpol,
    input logic                       glob_pol,
    input logic [CS_LINES-1:0]        line_pol,
    input logic                       done_ie,
    input logic                       rxr_ie,
    input logic                       busy,
    input logic                       sclk,
    input logic [CS_LINES-1:0]        cs_o,
    input logic [$clog2(DEPTH+1)-1:0] tx_count,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic                       tx_pop,
    input logic                       irq
);
    localparam int CW = $clog2(DEPTH + 1);

    a_r5_cs_idle: assert property (@(posedge clk) disable iff (rst)
        !run |-> (cs_o == ~(line_pol | {CS_LINES{glob_pol}})));

    a_r2_fifo_bound: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    a_r11_no_start_full: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> (rx_count < CW'(DEPTH)));

    a_r6_done_irq: assert property (@(posedge clk) disable iff (rst)
        (run && tx_count == '0 && !busy && done_ie) |-> irq);

    a_r8_need_irq: assert property (@(posedge clk) disable iff (rst)
        (rx_count >= CW'(NEED) && rxr_ie) |-> irq);

    a_r3_sclk_rest: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cpol));

    a_r12_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (!run && $past(!run)) |-> (!busy && sclk == cpol));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.DEPTH(FIFO_DEPTH), .NEED(RX_NEED_LEVEL)) u_chk (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .cpol(ctrl_q.cpol),
    .glob_pol(ctrl_q.glob_pol), .line_pol(ctrl_q.line_pol),
    .done_ie(ctrl_q.done_ie), .rxr_ie(ctrl_q.rxr_ie), .busy(eng_busy),
    .sclk(sclk), .cs_o(cs_o), .tx_count(tx_count), .rx_count(rx_count),
    .tx_pop(eng_tx_pop), .irq(irq)
);

// File: tb/spi_host_ctrl_test.sv
`timescale 1ns/1ps
module spi_host_ctrl_test;
    import spi_host_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        sclk, mosi, irq;
    logic        miso = 1'b0;
    logic [2:0]  cs_o;

    int vectors = 0, miscompares = 0;
    bit finished = 0;
    ctrl_t sh = '0;

    always #2.5 clk = ~clk;

    spi_host_ctrl uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] sel, input logic cpha, cpol, glob,
                                       run, die, rie, input logic [2:0] lp, input logic ctx, crx);
        logic [31:0] w = '0;
        w[1:0] = sel; w[2] = cpha; w[3] = cpol; w[4] = ctx; w[5] = crx;
        w[6] = glob; w[7] = run; w[9] = die; w[10] = rie; w[23:21] = lp;
        return w;
    endfunction

    // R5: chip-select level predicted every clock from the last control write
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [2:0] e;
            for (int i = 0; i < 3; i++) begin
                logic lvl;
                lvl  = sh.glob_pol | sh.line_pol[i];
                e[i] = (sh.run && sh.sel == 2'(i)) ? lvl : ~lvl;
            end
            chk("R5 cs level", {29'b0, cs_o}, {29'b0, e});
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        if (a == 4'h0) sh = ctrl_from_word(d);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int g = 0; g < 3000; g++) begin
            bus_rd(4'h0, s);
            if (s[16]) return;
        end
        chk("R6 finished never seen", 32'h0, 32'h1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural SPI slave
    logic [7:0] sl_q[$];
    logic [7:0] got_q[$];
    logic [7:0] sl_cur = '0, sl_rx = '0;
    int         sl_bit = 0;

    task automatic prep_slave();
        sl_bit = 0;
        sl_rx  = '0;
        sl_cur = (sl_q.size() > 0) ? sl_q.pop_front() : 8'h00;
        miso   = sl_cur[7];
    endtask

    always @(sclk) begin
        if (!rst && sh.run) begin
            if (sclk != sh.cpol) begin          // leading edge
                if (!sh.cpha) sl_rx = {sl_rx[6:0], mosi};
                else          miso  = sl_cur[7 - sl_bit];
            end else begin                       // trailing edge
                if (sh.cpha) sl_rx = {sl_rx[6:0], mosi};
                sl_bit++;
                if (sl_bit == 8) begin
                    got_q.push_back(sl_rx);
                    sl_bit = 0;
                    sl_cur = (sl_q.size() > 0) ? sl_q.pop_front() : 8'h00;
                    if (!sh.cpha) miso = sl_cur[7];
                end else if (!sh.cpha) begin
                    miso = sl_cur[7 - sl_bit];
                end
            end
        end
    end

    task automatic half_period(output int n);
        logic s0;
        s0 = sclk;
        for (int g = 0; g < 70000 && sclk == s0; g++) @(negedge clk);
        s0 = sclk;
        n  = 0;
        while (sclk == s0 && n < 70000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic div_case(input logic [15:0] dv, input int exp_half);
        int n;
        logic [31:0] s;
        sl_q.delete(); got_q.delete();
        bus_wr(4'h8, {16'h0, dv});
        bus_wr(4'h4, 32'h0000_00E7);
        prep_slave();
        bus_wr(4'h0, mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0));
        half_period(n);
        chk("R4 half period", n, exp_half);
        bus_wr(4'h0, mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0));
        idle(1);
        chk("R12 sclk idle after abort", {31'b0, sclk}, 32'h0);
        bus_rd(4'h0, s);
        chk("R12 no partial byte", {31'b0, s[17]}, 32'h0);
    endtask

    initial begin
        logic [31:0] d, s;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_rd(4'h0, s); chk("R1 reset status", s, 32'h0004_0000);
        bus_rd(4'h8, d); chk("R1 reset divider", d, 32'h0);
        chk("R1 reset cs", {29'b0, cs_o}, 32'h7);
        chk("R9 reset irq", {31'b0, irq}, 32'h0);
        bus_rd(4'h4, d); chk("R2 empty read", d, 32'h0);

        // R6/R9 run with empty FIFO: finished at once
        bus_wr(4'h0, mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0));
        chk("R9 irq on finished", {31'b0, irq}, 32'h1);
        bus_rd(4'h0, s); chk("R6 finished status", s, 32'h0005_0280);
        bus_wr(4'h0, 32'h0);
        chk("R9 irq cleared", {31'b0, irq}, 32'h0);

        // R3 four modes
        for (int m = 0; m < 4; m++) begin
            logic [15:0] dv;
            logic [1:0]  sl;
            logic [2:0]  lp;
            logic [7:0]  tb[3], rb[3];
            dv = (m == 0) ? 16'd4 : (m == 1) ? 16'd6 : (m == 2) ? 16'd2 : 16'd10;
            sl = 2'(m % 3);
            lp = (m == 2) ? 3'b100 : (m == 3) ? 3'b001 : 3'b000;
            sl_q.delete(); got_q.delete();
            for (int k = 0; k < 3; k++) begin
                tb[k] = 8'(8'h5A + 8'h37 * k + m);
                rb[k] = 8'hC3 ^ 8'(k * 29 + m * 7);
                sl_q.push_back(rb[k]);
            end
            bus_wr(4'h8, {16'h0, dv});
            bus_wr(4'h0, mk(sl, m[0], m[1], m == 1, 1'b0, 1'b0, 1'b0, lp, 1'b0, 1'b0));
            for (int k = 0; k < 3; k++) bus_wr(4'h4, {24'h0, tb[k]});
            prep_slave();
            bus_wr(4'h0, mk(sl, m[0], m[1], m == 1, 1'b1, 1'b0, 1'b0, lp, 1'b0, 1'b0));
            chk("R5 selected line active", {31'b0, cs_o[sl]}, {31'b0, (m == 1) | lp[sl]});
            wait_done();
            for (int k = 0; k < 3; k++) begin
                bus_rd(4'h4, d);
                chk("R3 received byte", d, {24'h0, rb[k]});
                chk("R3 sent byte", {24'h0, (got_q.size() > k) ? got_q[k] : 8'hxx}, {24'h0, tb[k]});
            end
            chk("R3 sclk rests at polarity", {31'b0, sclk}, {31'b0, m[1]});
            bus_wr(4'h0, mk(sl, m[0], m[1], m == 1, 1'b0, 1'b0, 1'b0, lp, 1'b0, 1'b0));
        end

        // R5 index 3 selects no line
        bus_wr(4'h0, mk(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0));
        chk("R5 index 3 none", {29'b0, cs_o}, 32'h7);
        bus_wr(4'h0, 32'h0);

        // R4 divider timing, R12 abort
        div_case(16'd6, 3);
        bus_rd(4'h8, d); chk("R4 divider readback", d, 32'h6);
        div_case(16'd7, 3);
        div_case(16'd0, 32768);

        // R8 threshold with 13 bytes
        sl_q.delete(); got_q.delete();
        bus_wr(4'h8, 32'd2);
        for (int k = 0; k < 13; k++) begin
            sl_q.push_back(8'(k * 11 + 3));
            bus_wr(4'h4, 32'(8'h80 + k));
        end
        prep_slave();
        bus_wr(4'h0, mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0, 1'b0));
        wait_done();
        bus_rd(4'h0, s);
        chk("R8 need-read at 13", {31'b0, s[19]}, 32'h1);
        chk("R9 irq need-read", {31'b0, irq}, 32'h1);
        bus_rd(4'h4, d); chk("R3 first byte of 13", d, 32'h3);
        bus_rd(4'h0, s); chk("R8 need-read at 12", {31'b0, s[19]}, 32'h1);
        bus_rd(4'h4, d);
        bus_rd(4'h0, s); chk("R8 need-read clear at 11", {31'b0, s[19]}, 32'h0);
        chk("R9 irq low below level", {31'b0, irq}, 32'h0);
        chk("R7 rx non-empty", {31'b0, s[17]}, 32'h1);
        bus_wr(4'h0, mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0, 1'b1));
        bus_rd(4'h0, s);
        chk("R10 rx cleared", {31'b0, s[17]}, 32'h0);
        chk("R10 clear bits read 0", {30'b0, s[5:4]}, 32'h0);
        bus_rd(4'h4, d); chk("R2 read after clear", d, 32'h0);

        // R11 stall on full, R2 overflow drop, R7 full flags
        sl_q.delete(); got_q.delete();
        for (int k = 0; k < 18; k++) sl_q.push_back(8'(k + 8'h40));
        for (int k = 0; k < 17; k++) bus_wr(4'h4, 32'(k + 8'h10));
        bus_rd(4'h0, s); chk("R7 tx full no room", {31'b0, s[18]}, 32'h0);
        prep_slave();
        bus_wr(4'h0, mk(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0));
        wait_done();
        bus_rd(4'h0, s); chk("R7 rx full", {31'b0, s[20]}, 32'h1);
        bus_wr(4'h4, 32'h0000_00AA);
        bus_wr(4'h4, 32'h0000_00BB);
        idle(100);
        bus_rd(4'h0, s);
        chk("R11 stalled not finished", {31'b0, s[16]}, 32'h0);
        chk("R11 sent only 16", got_q.size(), 16);
        bus_rd(4'h4, d); chk("R11 first byte kept", d, 32'h40);
        idle(60);
        chk("R11 resumed one byte", got_q.size(), 17);
        chk("R2 overflow dropped", {24'h0, (got_q.size() > 16) ? got_q[16] : 8'h00}, 32'hAA);
        bus_rd(4'h0, s);
        chk("R11 full again", {31'b0, s[20]}, 32'h1);
        chk("R6 byte pending", {31'b0, s[16]}, 32'h0);
        bus_wr(4'h0, mk(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 1'b1));

        // R10 clear transmit FIFO
        for (int k = 0; k < 3; k++) bus_wr(4'h4, 32'h55);
        bus_wr(4'h0, mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0));
        bus_wr(4'h0, mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0));
        chk("R10 tx cleared finished", {31'b0, irq}, 32'h1);
        idle(20);
        chk("R10 no clocking", {31'b0, sclk}, 32'h0);
        bus_rd(4'h0, s); chk("R10 nothing received", {31'b0, s[17]}, 32'h0);
        bus_wr(4'h0, 32'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule